// File: doc/BRIEF.md
# Coherence message wire-class steering

This block sits on the outgoing message port of a directory coherence controller and steers every message onto one of three physical link classes. The fast class is narrow and low-latency. The base class is the general-purpose link. The power class is slow but cheap in switching energy. Each message arrives with a 4-bit type code, a length and a payload. A per-type table, set by a parameter, picks the class from the protocol role of the message. Messages on the critical path of a transaction go to the fast class. Messages whose latency is hidden behind a longer chain of hops go to the power class. Everything else goes to the base class.

Each class has its own 4-entry queue and its own valid/ready output, so a stalled link holds back only its own traffic. The base and power outputs carry a whole message per transfer. The fast output is only `FAST_W` bits wide, so a message that is allowed on the fast class leaves there as consecutive beats, and the final beat is marked. A critical message longer than the fast class accepts is sent on the base class instead.

Top module: `coh_wire_steer`

## Requirements
- R1: After reset, `fast_valid_o`, `base_valid_o` and `pwr_valid_o` are low and `in_ready_o` is high.
- R2: With the default table and `in_size_i` below `FAST_MAX_BEATS` (default 2), the critical types go to the fast class. These are invalidate (type 2), invalidate acknowledge (type 3), forwarded dirty copy from the owner (type 5) and negative acknowledge (type 8).
- R3: With the default table, the non-critical types go to the power class at any size. These are the clean data copy to the requester (type 4), the speculative reply (type 6) and the writeback data (type 7).
- R4: With the default table, the types 0, 1 and 9 to 15 go to the base class. Type 0 is a read request and type 1 is a read-exclusive request.
- R5: A message whose table class is fast but whose `in_size_i` is `FAST_MAX_BEATS` or more goes to the base class, and its size and payload are unchanged.
- R6: `in_size_i` holds the number of `FAST_W`-bit beats minus one. A fast-class message leaves as `in_size_i`+1 beats, starting with the lowest payload bits. `fast_last_o` is high only on the final beat, and `fast_type_o` is valid on every beat. While `fast_ready_i` is low, the beat on the fast output holds steady.
- R7: Within one class, messages leave in the order they were accepted.
- R8: Each class queue holds 4 messages. `in_ready_o` is low only when the queue of the class the present input maps to is full.
- R9: A full or stalled class does not block the acceptance or the output of messages that map to another class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input message valid |
| in_ready_o | output | 1 | Input message accepted when high together with valid |
| in_type_i | input | 4 | Message type code |
| in_size_i | input | 2 | Payload length in fast beats, minus one |
| in_data_i | input | 64 | Message payload |
| fast_valid_o | output | 1 | Fast class beat valid |
| fast_ready_i | input | 1 | Fast link accepts beat |
| fast_type_o | output | 4 | Type of message on fast class |
| fast_data_o | output | 16 | Current payload beat |
| fast_last_o | output | 1 | Final beat of message |
| base_valid_o | output | 1 | Base class message valid |
| base_ready_i | input | 1 | Base link accepts message |
| base_type_o | output | 4 | Base message type |
| base_size_o | output | 2 | Base message size |
| base_data_o | output | 64 | Base message payload |
| pwr_valid_o | output | 1 | Power class message valid |
| pwr_ready_i | input | 1 | Power link accepts message |
| pwr_type_o | output | 4 | Power message type |
| pwr_size_o | output | 2 | Power message size |
| pwr_data_o | output | 64 | Power message payload |

## Verification
A wrong class decision shows up on the output valid of the wrong class one cycle after acceptance, so every routing test checks all three valids at that point. A corrupted queue pointer shows up as a type or payload out of order at the first pop after it. A miscounted occupancy shows up as `in_ready_o` dropping too early or too late at the fourth or fifth push into a held class. A wrong beat counter shows up within one message as a shifted slice or a misplaced last flag.

// File: rtl/coh_steer_pkg.sv
package coh_steer_pkg;

  localparam int TYPE_W = 4;
  localparam int NTYPES = 1 << TYPE_W;
  localparam int NCLS   = 3;

  typedef enum logic [1:0] {
    CLS_FAST = 2'd0,
    CLS_BASE = 2'd1,
    CLS_PWR  = 2'd2
  } cls_e;

  localparam logic [TYPE_W-1:0] T_RD_REQ     = 4'd0;
  localparam logic [TYPE_W-1:0] T_RDX_REQ    = 4'd1;
  localparam logic [TYPE_W-1:0] T_INVAL      = 4'd2;
  localparam logic [TYPE_W-1:0] T_INVAL_ACK  = 4'd3;
  localparam logic [TYPE_W-1:0] T_CLEAN_DATA = 4'd4;
  localparam logic [TYPE_W-1:0] T_FWD_DIRTY  = 4'd5;
  localparam logic [TYPE_W-1:0] T_SPEC_REPLY = 4'd6;
  localparam logic [TYPE_W-1:0] T_WB_DATA    = 4'd7;
  localparam logic [TYPE_W-1:0] T_NACK       = 4'd8;

  function automatic logic [NTYPES*2-1:0] default_map();
    logic [NTYPES*2-1:0] m;
    for (int t = 0; t < NTYPES; t++) begin
      case (t)
        2, 3, 5, 8: m[t*2 +: 2] = CLS_FAST;
        4, 6, 7:    m[t*2 +: 2] = CLS_PWR;
        default:    m[t*2 +: 2] = CLS_BASE;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/coh_steer_fifo.sv
module coh_steer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r8_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r7_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !pop_i) |=> (!empty_o && $stable(rdata_o)));
endmodule

// File: rtl/coh_steer_classify.sv
module coh_steer_classify
  import coh_steer_pkg::*;
#(
  parameter int                  SZ_W           = 2,
  parameter int                  FAST_MAX_BEATS = 2,
  parameter logic [NTYPES*2-1:0] CLASS_MAP      = default_map()
) (
  input  logic [TYPE_W-1:0] type_i,
  input  logic [SZ_W-1:0]   size_i,
  output cls_e              cls_o
);
  logic [1:0] raw;

  always_comb begin
    raw = CLASS_MAP[type_i*2 +: 2];
    if (raw == 2'd3) cls_o = CLS_BASE;
    else             cls_o = cls_e'(raw);
    // fast class is narrow: long critical messages fall back to base
    if (cls_o == CLS_FAST && 32'(size_i) >= FAST_MAX_BEATS) cls_o = CLS_BASE;
  end
endmodule

// File: rtl/coh_steer_serializer.sv
module coh_steer_serializer
  import coh_steer_pkg::*;
#(
  parameter int SZ_W   = 2,
  parameter int PAY_W  = 64,
  parameter int FAST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [PAY_W-1:0]  data_i,
  output logic              pop_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [TYPE_W-1:0] type_o,
  output logic [FAST_W-1:0] data_o,
  output logic              last_o
);
  logic [SZ_W-1:0] beat_q;
  logic            fire;

  assign valid_o = !empty_i;
  assign type_o  = type_i;
  assign data_o  = data_i[beat_q*FAST_W +: FAST_W];
  assign last_o  = valid_o && (beat_q == size_i);
  assign fire    = valid_o && ready_i;
  assign pop_o   = fire && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (pop_o)  beat_q <= '0;
    else if (fire)   beat_q <= beat_q + 1'b1;
  end

  a_r6_beat_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (beat_q <= size_i));
  a_r6_fast_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));
  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (beat_q == '0));
endmodule

// File: rtl/coh_wire_steer.sv
module coh_wire_steer
  import coh_steer_pkg::*;
#(
  parameter int                  PAY_W          = 64,
  parameter int                  FAST_W         = 16,
  parameter int                  SZ_W           = 2,
  parameter int                  FAST_MAX_BEATS = 2,
  parameter int                  Q_DEPTH        = 4,
  parameter logic [NTYPES*2-1:0] CLASS_MAP      = default_map()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [TYPE_W-1:0] in_type_i,
  input  logic [SZ_W-1:0]   in_size_i,
  input  logic [PAY_W-1:0]  in_data_i,
  output logic              fast_valid_o,
  input  logic              fast_ready_i,
  output logic [TYPE_W-1:0] fast_type_o,
  output logic [FAST_W-1:0] fast_data_o,
  output logic              fast_last_o,
  output logic              base_valid_o,
  input  logic              base_ready_i,
  output logic [TYPE_W-1:0] base_type_o,
  output logic [SZ_W-1:0]   base_size_o,
  output logic [PAY_W-1:0]  base_data_o,
  output logic              pwr_valid_o,
  input  logic              pwr_ready_i,
  output logic [TYPE_W-1:0] pwr_type_o,
  output logic [SZ_W-1:0]   pwr_size_o,
  output logic [PAY_W-1:0]  pwr_data_o
);
  localparam int MW = TYPE_W + SZ_W + PAY_W;

  cls_e           cls;
  logic [MW-1:0]  wdata;
  logic [MW-1:0]  rdata [NCLS];
  logic [NCLS-1:0] push, pop, full, empty;
  logic           fast_pop;

  coh_steer_classify #(
    .SZ_W(SZ_W), .FAST_MAX_BEATS(FAST_MAX_BEATS), .CLASS_MAP(CLASS_MAP)
  ) u_classify (
    .type_i(in_type_i), .size_i(in_size_i), .cls_o(cls)
  );

  assign wdata      = {in_type_i, in_size_i, in_data_i};
  assign in_ready_o = !full[cls];

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign push[g] = in_valid_i && in_ready_o && (cls == cls_e'(g));
    coh_steer_fifo #(.W(MW), .DEPTH(Q_DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(push[g]), .wdata_i(wdata), .full_o(full[g]),
      .pop_i(pop[g]), .empty_o(empty[g]), .rdata_o(rdata[g])
    );
  end

  assign pop[CLS_FAST] = fast_pop;
  assign pop[CLS_BASE] = base_valid_o && base_ready_i;
  assign pop[CLS_PWR]  = pwr_valid_o && pwr_ready_i;

  coh_steer_serializer #(.SZ_W(SZ_W), .PAY_W(PAY_W), .FAST_W(FAST_W)) u_ser (
    .clk_i, .rst_ni,
    .empty_i(empty[CLS_FAST]),
    .type_i(rdata[CLS_FAST][MW-1 -: TYPE_W]),
    .size_i(rdata[CLS_FAST][PAY_W +: SZ_W]),
    .data_i(rdata[CLS_FAST][PAY_W-1:0]),
    .pop_o(fast_pop),
    .valid_o(fast_valid_o), .ready_i(fast_ready_i),
    .type_o(fast_type_o), .data_o(fast_data_o), .last_o(fast_last_o)
  );

  assign base_valid_o = !empty[CLS_BASE];
  assign {base_type_o, base_size_o, base_data_o} = rdata[CLS_BASE];
  assign pwr_valid_o  = !empty[CLS_PWR];
  assign {pwr_type_o, pwr_size_o, pwr_data_o} = rdata[CLS_PWR];

  a_r5_wide_not_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push[CLS_FAST] |-> (32'(in_size_i) < FAST_MAX_BEATS));
  a_r8_stall_has_backlog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |->
      ($countones({fast_valid_o, base_valid_o, pwr_valid_o}) >= 1));
  a_r8_single_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push));
  a_r8_accept_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> (push != '0));
endmodule

// File: tb/coh_wire_steer_bench.sv
module coh_wire_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [3:0]  in_type = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_data = '0;
  logic        fast_valid, fast_ready = 1'b0, fast_last;
  logic [3:0]  fast_type;
  logic [15:0] fast_data;
  logic        base_valid, base_ready = 1'b0;
  logic [3:0]  base_type;
  logic [1:0]  base_size;
  logic [63:0] base_data;
  logic        pwr_valid, pwr_ready = 1'b0;
  logic [3:0]  pwr_type;
  logic [1:0]  pwr_size;
  logic [63:0] pwr_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  coh_wire_steer u_coh_wire_steer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_type_i(in_type), .in_size_i(in_size), .in_data_i(in_data),
    .fast_valid_o(fast_valid), .fast_ready_i(fast_ready),
    .fast_type_o(fast_type), .fast_data_o(fast_data), .fast_last_o(fast_last),
    .base_valid_o(base_valid), .base_ready_i(base_ready),
    .base_type_o(base_type), .base_size_o(base_size), .base_data_o(base_data),
    .pwr_valid_o(pwr_valid), .pwr_ready_i(pwr_ready),
    .pwr_type_o(pwr_type), .pwr_size_o(pwr_size), .pwr_data_o(pwr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pay(input int n);
    return {16'(n + 16'hA000), 16'(n + 16'hB000), 16'(n + 16'hC000), 16'(n + 16'hD000)};
  endfunction

  task automatic push_msg(input logic [3:0] t, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_type = t; in_size = s; in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // valids expected after all pushes have settled
  task automatic chk_valids(input bit f, input bit b, input bit p, input string req);
    @(negedge clk);
    chk(fast_valid == f, req, "fast_valid", 64'(fast_valid), 64'(f));
    chk(base_valid == b, req, "base_valid", 64'(base_valid), 64'(b));
    chk(pwr_valid == p,  req, "pwr_valid",  64'(pwr_valid),  64'(p));
  endtask

  task automatic pop_base(input logic [3:0] t, input logic [1:0] s,
                          input logic [63:0] d, input string req);
    @(negedge clk);
    chk(base_valid, req, "base_valid", 64'(base_valid), 64'd1);
    chk(base_type == t && base_size == s, req, "base type/size",
        64'({base_type, base_size}), 64'({t, s}));
    chk(base_data == d, req, "base data", base_data, d);
    base_ready = 1'b1;
    @(posedge clk); #1;
    base_ready = 1'b0;
  endtask

  task automatic pop_pwr(input logic [3:0] t, input logic [1:0] s,
                         input logic [63:0] d, input string req);
    @(negedge clk);
    chk(pwr_valid, req, "pwr_valid", 64'(pwr_valid), 64'd1);
    chk(pwr_type == t && pwr_size == s, req, "pwr type/size",
        64'({pwr_type, pwr_size}), 64'({t, s}));
    chk(pwr_data == d, req, "pwr data", pwr_data, d);
    pwr_ready = 1'b1;
    @(posedge clk); #1;
    pwr_ready = 1'b0;
  endtask

  task automatic pop_fast(input logic [3:0] t, input logic [1:0] s,
                          input logic [63:0] d, input string req);
    for (int k = 0; k <= int'(s); k++) begin
      @(negedge clk);
      chk(fast_valid && fast_type == t, req, "fast valid/type",
          64'({fast_valid, fast_type}), 64'({1'b1, t}));
      chk(fast_data == d[k*16 +: 16], "R6", "fast beat", 64'(fast_data), 64'(d[k*16 +: 16]));
      chk(fast_last == (k == int'(s)), "R6", "fast last", 64'(fast_last), 64'(k == int'(s)));
      fast_ready = 1'b1;
      @(posedge clk); #1;
      fast_ready = 1'b0;
    end
  endtask

  task automatic t_reset;
    #1;
    chk(!fast_valid && !base_valid && !pwr_valid, "R1", "valids in reset",
        64'({fast_valid, base_valid, pwr_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fast_valid && !base_valid && !pwr_valid, "R1", "valids after reset",
        64'({fast_valid, base_valid, pwr_valid}), 64'd0);
    chk(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_critical;
    push_msg(4'd2, 2'd0, pay(1));
    push_msg(4'd3, 2'd0, pay(2));
    push_msg(4'd8, 2'd0, pay(3));
    push_msg(4'd5, 2'd1, pay(4));
    chk_valids(1'b1, 1'b0, 1'b0, "R2");
    pop_fast(4'd2, 2'd0, pay(1), "R2");
    pop_fast(4'd3, 2'd0, pay(2), "R7");
    pop_fast(4'd8, 2'd0, pay(3), "R7");
    pop_fast(4'd5, 2'd1, pay(4), "R2");
    chk_valids(1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_noncritical;
    push_msg(4'd4, 2'd3, pay(10));
    push_msg(4'd6, 2'd0, pay(11));
    push_msg(4'd7, 2'd2, pay(12));
    chk_valids(1'b0, 1'b0, 1'b1, "R3");
    pop_pwr(4'd4, 2'd3, pay(10), "R3");
    pop_pwr(4'd6, 2'd0, pay(11), "R7");
    pop_pwr(4'd7, 2'd2, pay(12), "R3");
    chk_valids(1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_base_types;
    push_msg(4'd0, 2'd0, pay(20));
    push_msg(4'd1, 2'd1, pay(21));
    push_msg(4'd9, 2'd0, pay(22));
    push_msg(4'd15, 2'd3, pay(23));
    chk_valids(1'b0, 1'b1, 1'b0, "R4");
    pop_base(4'd0, 2'd0, pay(20), "R4");
    pop_base(4'd1, 2'd1, pay(21), "R7");
    pop_base(4'd9, 2'd0, pay(22), "R4");
    pop_base(4'd15, 2'd3, pay(23), "R4");
  endtask

  task automatic t_wide_fallback;
    push_msg(4'd5, 2'd3, pay(30));
    push_msg(4'd8, 2'd2, pay(31));
    chk_valids(1'b0, 1'b1, 1'b0, "R5");
    pop_base(4'd5, 2'd3, pay(30), "R5");
    pop_base(4'd8, 2'd2, pay(31), "R5");
    chk_valids(1'b0, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_fast_stall;
    logic [15:0] first;
    push_msg(4'd3, 2'd1, pay(40));
    @(negedge clk);
    first = fast_data;
    repeat (3) @(negedge clk);
    chk(fast_valid && fast_data == first && !fast_last, "R6", "stalled beat held",
        64'(fast_data), 64'(first));
    pop_fast(4'd3, 2'd1, pay(40), "R6");
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) push_msg(4'd0, 2'd0, pay(50 + i));
    @(negedge clk);
    in_valid = 1'b1; in_type = 4'd0; in_size = 2'd0; in_data = pay(60);
    #1;
    chk(!in_ready, "R8", "ready with base full", 64'(in_ready), 64'd0);
    in_type = 4'd8;
    #1;
    chk(in_ready, "R9", "ready for fast while base full", 64'(in_ready), 64'd1);
    in_type = 4'd6;
    #1;
    chk(in_ready, "R9", "ready for pwr while base full", 64'(in_ready), 64'd1);
    in_valid = 1'b0;
    push_msg(4'd8, 2'd0, pay(61));
    push_msg(4'd6, 2'd0, pay(62));
    chk_valids(1'b1, 1'b1, 1'b1, "R9");
    pop_fast(4'd8, 2'd0, pay(61), "R9");
    pop_pwr(4'd6, 2'd0, pay(62), "R9");
    pop_base(4'd0, 2'd0, pay(50), "R7");
    @(negedge clk);
    in_valid = 1'b1; in_type = 4'd1; in_size = 2'd0; in_data = pay(63);
    #1;
    chk(in_ready, "R8", "ready after one base pop", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    for (int i = 1; i < 4; i++) pop_base(4'd0, 2'd0, pay(50 + i), "R7");
    pop_base(4'd1, 2'd0, pay(63), "R7");
    chk_valids(1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_critical();
    t_noncritical();
    t_base_types();
    t_wide_fallback();
    t_fast_stall();
    t_full();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule